// File: doc/BRIEF.md
# Atomic Output Pin Register Bank

This block holds the output levels of a 16-pin output port behind a simple synchronous register bus. The bus has a word address, a write strobe, 32-bit write data and combinational read data. Software can change the pin state in four ways, and each one is a single bus write. A whole-port write replaces every level. A combined set/clear write raises some pins and lowers others. A clear-only write lowers the selected pins. A group of conditional aliases uses address bits to say whether the write may alter pins that are now high, pins that are now low, or both.

Every new value is worked out from the registered pin state in the same cycle as the write and is stored at that clock edge. Two writes from unrelated software contexts, even on consecutive cycles, therefore never undo each other. No read-modify-write sequence is ever needed.

A small gate state machine sits in front of all the data registers. It has two states. In GATE_OFF, which is the reset state, the bank ignores every write except a write to the gate register, and every read returns zero. In GATE_ON, all registers work. The transition GATE_OFF to GATE_ON is taken on a gate write with data bit 0 at 1. The transition GATE_ON to GATE_OFF is taken on a gate write with data bit 0 at 0. Any other cycle keeps the present state.

Top module: `pin_drive_bank`

## Requirements
- R1: A synchronous reset clears all 16 pin outputs to 0 and puts the gate in GATE_OFF. After reset, a read of word 3 returns 0.
- R2: A write to word 3 is accepted in either gate state. Write-data bit 0 set to 1 moves the gate to GATE_ON, and set to 0 moves it to GATE_OFF. In GATE_ON a read of word 3 returns 0x0000_0001.
- R3: In GATE_OFF, writes to any word other than 3 leave the pins unchanged, and every read returns 0.
- R4: In GATE_ON, a write to word 0 loads write-data bits [15:0] onto the pins at the next clock edge. A read of word 0 returns the pin state in bits [15:0], with zeros above.
- R5: In GATE_ON, a write to word 1 drives pin n high where bit n is 1 and low where bit n+16 is 1, for n from 0 to 15. When both bits are 1 the pin goes high. Pins with neither bit set keep their level.
- R6: In GATE_ON, a write to word 2 drives pin n low where write-data bit n is 1. All other pins are unchanged, and write-data bits [31:16] are ignored.
- R7: In GATE_ON, words 8 to 11 are conditional aliases. Address bit 1 lets the write change pins that are currently 1, and address bit 0 lets it change pins that are currently 0. A pin that may change takes write-data bit n. Word 11 therefore behaves as a whole-port write.
- R8: In GATE_ON, a write to word 8, where neither qualifying bit is set, leaves the pins unchanged.
- R9: Reads of words 1, 2, 4 to 15 return 0. Writes to words 4 to 7 and 12 to 15 leave the pins unchanged.
- R10: Two writes on consecutive cycles both take effect. The second write acts on the pin state left by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Word address |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| pin_out | output | 16 | Registered output pin levels |

## Verification
The conditional aliases are the hardest part to cover. A write to an alias tells nothing unless the pins already hold a mix of ones and zeros, and unless the data disagrees with the present state on both kinds of pin. Otherwise a wrong choice of which pins may change looks the same as a right one. The stimulus first loads mixed patterns through the whole-port and set/clear words. It then sends alias writes whose data differs from the state in both directions. A long random run interleaves all the words, including gate toggles and back-to-back writes, so each alias write starts from an arbitrary earlier state.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    // kind of bus access selected by the word address
    typedef enum logic [2:0] {
        OP_NONE,
        OP_DATA,
        OP_SETCLR,
        OP_CLR,
        OP_GATE,
        OP_COND
    } op_kind_t;

    // access gate states
    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_t;
endpackage

// File: rtl/pin_bank_decode.sv
module pin_bank_decode
    import pin_bank_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output op_kind_t          op,
    output logic              may_touch_ones,
    output logic              may_touch_zeros
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [ADDR_W-1:0] W_DATA   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] W_SETCLR = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] W_CLR    = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] W_GATE   = ADDR_W'(3);
    // alias group: upper address bits equal 1 followed by zeros
    localparam logic [ADDR_W-3:0] COND_BASE = (ADDR_W-2)'(1) << (ADDR_W-3);

    always_comb begin
        op              = OP_NONE;
        may_touch_ones  = 1'b0;
        may_touch_zeros = 1'b0;
        if (addr == W_DATA) begin
            op = OP_DATA;
        end else if (addr == W_SETCLR) begin
            op = OP_SETCLR;
        end else if (addr == W_CLR) begin
            op = OP_CLR;
        end else if (addr == W_GATE) begin
            op = OP_GATE;
        end else if (addr[ADDR_W-1:2] == COND_BASE) begin
            op              = OP_COND;
            may_touch_ones  = addr[1];
            may_touch_zeros = addr[0];
        end
    end
endmodule

// File: rtl/pin_bank_next.sv
module pin_bank_next
    import pin_bank_pkg::*;
#(
    parameter int PINS   = 16,
    parameter int DATA_W = 32
) (
    input  op_kind_t          op,
    input  logic              may_touch_ones,
    input  logic              may_touch_zeros,
    input  logic [PINS-1:0]   cur,
    input  logic [DATA_W-1:0] wdata,
    output logic [PINS-1:0]   nxt
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [PINS-1:0] lo_half;
    logic [PINS-1:0] hi_half;
    logic [PINS-1:0] cond_mask;

    assign lo_half = wdata[PINS-1:0];
    assign hi_half = wdata[2*PINS-1:PINS];

    // pins an alias write is allowed to alter, chosen by their present level
    assign cond_mask = ({PINS{may_touch_ones}} & cur) | ({PINS{may_touch_zeros}} & ~cur);

    always_comb begin
        unique case (op)
            OP_DATA:   nxt = lo_half;
            OP_SETCLR: nxt = (cur & ~hi_half) | lo_half;   // set bit dominates
            OP_CLR:    nxt = cur & ~lo_half;
            OP_COND:   nxt = (cur & ~cond_mask) | (lo_half & cond_mask);
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/pin_bank_gate.sv
module pin_bank_gate
    import pin_bank_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic gate_wr,
    input  logic gate_val,
    output logic gate_on
);
    timeunit 1ns;
    timeprecision 100ps;

    gate_state_t state_q;
    gate_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: if (gate_wr && gate_val)  state_d = GATE_ON;
            GATE_ON:  if (gate_wr && !gate_val) state_d = GATE_OFF;
            default:  state_d = GATE_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GATE_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            GATE_ON: gate_on = 1'b1;
            default: gate_on = 1'b0;
        endcase
    end
endmodule

// File: rtl/pin_drive_bank.sv
module pin_drive_bank
    import pin_bank_pkg::*;
#(
    parameter int PINS   = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PINS-1:0]   pin_out
);
    timeunit 1ns;
    timeprecision 100ps;

    op_kind_t        op;
    logic            touch_ones;
    logic            touch_zeros;
    logic            gate_on;
    logic [PINS-1:0] pins_q;
    logic [PINS-1:0] pins_d;
    logic            pin_wr;

    pin_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr            (bus_addr),
        .op              (op),
        .may_touch_ones  (touch_ones),
        .may_touch_zeros (touch_zeros)
    );

    pin_bank_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .gate_wr  (bus_we && (op == OP_GATE)),
        .gate_val (bus_wdata[0]),
        .gate_on  (gate_on)
    );

    pin_bank_next #(.PINS(PINS), .DATA_W(DATA_W)) u_next (
        .op              (op),
        .may_touch_ones  (touch_ones),
        .may_touch_zeros (touch_zeros),
        .cur             (pins_q),
        .wdata           (bus_wdata),
        .nxt             (pins_d)
    );

    assign pin_wr = bus_we && gate_on;

    always_ff @(posedge clk) begin
        if (rst)         pins_q <= '0;
        else if (pin_wr) pins_q <= pins_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (gate_on) begin
            unique case (op)
                OP_DATA: bus_rdata[PINS-1:0] = pins_q;
                OP_GATE: bus_rdata[0]        = 1'b1;
                default: bus_rdata           = '0;
            endcase
        end
    end

    assign pin_out = pins_q;
endmodule

// File: rtl/pin_drive_bank_chk.sv
module pin_drive_bank_chk #(
    parameter int PINS   = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PINS-1:0]   pin_out,
    input logic              gate_on
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [ADDR_W-1:0] W_DATA   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] W_SETCLR = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] W_CLR    = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] W_NONE   = ADDR_W'(8);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_out == '0 && !gate_on));

    assert_gated_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !gate_on |=> $stable(pin_out));

    assert_gated_read_R3: assert property (@(posedge clk) disable iff (rst)
        !gate_on |-> bus_rdata == '0);

    assert_data_load_R4: assert property (@(posedge clk) disable iff (rst)
        (gate_on && bus_we && bus_addr == W_DATA) |=> pin_out == $past(bus_wdata[PINS-1:0]));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (gate_on && bus_we && bus_addr == W_SETCLR) |=>
        ((pin_out & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0])));

    assert_setclr_untouched_R5: assert property (@(posedge clk) disable iff (rst)
        (gate_on && bus_we && bus_addr == W_SETCLR) |=>
        (((pin_out ^ $past(pin_out)) &
          ~($past(bus_wdata[PINS-1:0]) | $past(bus_wdata[2*PINS-1:PINS]))) == '0));

    assert_clear_only_R6: assert property (@(posedge clk) disable iff (rst)
        (gate_on && bus_we && bus_addr == W_CLR) |=>
        ((pin_out & $past(bus_wdata[PINS-1:0])) == '0 &&
         (pin_out | $past(bus_wdata[PINS-1:0])) == ($past(pin_out) | $past(bus_wdata[PINS-1:0]))));

    assert_alias_none_R8: assert property (@(posedge clk) disable iff (rst)
        (gate_on && bus_we && bus_addr == W_NONE) |=> $stable(pin_out));

    assert_wo_read_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == W_SETCLR || bus_addr == W_CLR) |-> bus_rdata == '0);
endmodule

bind pin_drive_bank pin_drive_bank_chk #(
    .PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .gate_on   (gate_on)
);

// File: tb/pin_drive_bank_tb.sv
module pin_drive_bank_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [15:0] exp_pins = '0;
    logic        exp_en = 1'b0;

    always #2.5 clk = ~clk;

    pin_drive_bank u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out)
    );

    // expected pin state after one write, written from the requirements
    function automatic logic [15:0] model_write(logic [3:0] a, logic [31:0] d,
                                                logic [15:0] cur, logic en);
        logic [15:0] r = cur;
        if (!en) return cur;
        if (a == 4'd0) r = d[15:0];
        else if (a == 4'd1 || a == 4'd2 || a[3:2] == 2'b10) begin
            for (int i = 0; i < 16; i++) begin
                if (a == 4'd1) begin
                    if (d[i]) r[i] = 1'b1;
                    else if (d[i+16]) r[i] = 1'b0;
                end else if (a == 4'd2) begin
                    if (d[i]) r[i] = 1'b0;
                end else if ((cur[i] && a[1]) || (!cur[i] && a[0])) begin
                    r[i] = d[i];
                end
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] model_read(logic [3:0] a, logic [15:0] cur, logic en);
        if (!en) return 32'h0;
        if (a == 4'd0) return {16'h0, cur};
        if (a == 4'd3) return 32'h1;
        return 32'h0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_model(logic [3:0] a, logic [31:0] d);
        if (a == 4'd3) exp_en = d[0];
        else exp_pins = model_write(a, d, exp_pins, exp_en);
    endtask

    task automatic wr(string req, logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        apply_model(a, d);
        @(negedge clk);
        bus_we = 1'b0;
        check(req, {16'h0, pin_out}, {16'h0, exp_pins});
    endtask

    // two writes on consecutive edges
    task automatic wr2(string req, logic [3:0] a1, logic [31:0] d1,
                       logic [3:0] a2, logic [31:0] d2);
        @(negedge clk);
        bus_addr = a1; bus_we = 1'b1; bus_wdata = d1;
        apply_model(a1, d1);
        @(negedge clk);
        check(req, {16'h0, pin_out}, {16'h0, exp_pins});
        bus_addr = a2; bus_wdata = d2;
        apply_model(a2, d2);
        @(negedge clk);
        bus_we = 1'b0;
        check(req, {16'h0, pin_out}, {16'h0, exp_pins});
    endtask

    task automatic rd(string req, logic [3:0] a);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1;
        check(req, bus_rdata, model_read(a, exp_pins, exp_en));
    endtask

    initial begin
        #(100000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pins after reset", {16'h0, pin_out}, 32'h0);
        rd("R1 gate read after reset", 4'd3);

        wr("R3 write while gated", 4'd0, 32'h0000_FFFF);
        rd("R3 read while gated", 4'd0);

        wr("R2 enable gate", 4'd3, 32'h1);
        rd("R2 gate readback", 4'd3);
        check("R2 gate value", bus_rdata, 32'h1);

        wr("R4 whole-port write", 4'd0, 32'h1234_A5C3);
        check("R4 literal", {16'h0, pin_out}, 32'h0000_A5C3);
        rd("R4 readback", 4'd0);

        wr("R5 group update", 4'd1, 32'h0070_0050);
        check("R5 group literal", {16'h0, pin_out}, 32'h0000_A5D3);
        wr("R5 set wins", 4'd1, 32'h0004_0004);
        check("R5 set wins literal", {16'h0, pin_out}, 32'h0000_A5D7);

        wr("R6 clear only", 4'd2, 32'hFFFF_00F0);
        check("R6 literal", {16'h0, pin_out}, 32'h0000_A507);

        wr("R8 alias none", 4'd8, 32'h0000_5AF8);
        wr("R7 alias zeros", 4'd9, 32'h0000_00F0);
        check("R7 zeros literal", {16'h0, pin_out}, 32'h0000_A5F7);
        wr("R7 alias ones", 4'd10, 32'h0000_0F0F);
        check("R7 ones literal", {16'h0, pin_out}, 32'h0000_0507);
        wr("R7 alias both", 4'd11, 32'h0000_BEEF);
        check("R7 both literal", {16'h0, pin_out}, 32'h0000_BEEF);

        wr("R9 unmapped write", 4'd12, 32'hFFFF_FFFF);
        wr("R9 unmapped write low", 4'd5, 32'h0000_0000);
        rd("R9 setclr read", 4'd1);
        rd("R9 clear read", 4'd2);
        rd("R9 alias read", 4'd11);
        rd("R9 unmapped read", 4'd13);

        wr2("R10 back to back", 4'd1, 32'h0000_0010, 4'd2, 32'h0000_0001);
        check("R10 literal", {16'h0, pin_out}, 32'h0000_BEFE);

        wr("R2 disable gate", 4'd3, 32'h0);
        rd("R3 gated data read", 4'd0);
        wr("R3 gated setclr", 4'd1, 32'hFFFF_0000);
        wr("R2 re-enable", 4'd3, 32'h1);
        rd("R4 state kept over gating", 4'd0);

        for (int n = 0; n < 400; n++) begin
            logic [3:0]  a;
            logic [31:0] d;
            a = 4'($urandom % 16);
            d = $urandom;
            if (a == 4'd3) d = {31'h0, ($urandom % 6) != 0};
            if (n % 7 == 0)
                wr2("R10 random pair", a, d, 4'($urandom % 12), $urandom & 32'hFFFF_FFF6);
            else
                wr("R7 random write", a, d);
            rd("R9 random read", 4'($urandom % 16));
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_pins = '0; exp_en = 1'b0;
        check("R1 pins after late reset", {16'h0, pin_out}, 32'h0);
        rd("R1 gate after late reset", 4'd3);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule